// File: doc/BRIEF.md
# Dual Chip-Select Strobe Timing Generator

This block produces the bus-cycle waveform for a flash or general-purpose peripheral hanging off a local bus with two chip selects. A single 32-bit timing word holds three 3-bit counts per chip select: the delay from chip-select assertion to strobe fall (setup), the strobe-low width (pulse), and the delay from strobe rise to chip-select release (hold). A zero setup or hold count means sixteen cycles. A zero pulse count means one cycle.

A request names a chip select and read or write. The block drives the chosen active-low chip select, waits out the setup count and pulls the matching active-low strobe low for the pulse count. If ready checking is enabled for that chip select, it then samples a synchronised ready line and stretches the strobe with wait states until ready is seen. It then raises the strobe, waits out the hold count, releases the chip select and pulses done for one cycle. Requests that arrive during a cycle are dropped. All bus outputs come straight from flops.

Top module: `cst_strobe_timer`

## Requirements
- R1: After reset the timing word reads 0x07770777. A full-word write replaces all 32 bits, and every bit, reserved ones included, reads back as last written.
- R2: Chip select 0 takes setup, pulse and hold from bits 2:0, 6:4 and 10:8. Chip select 1 takes them from bits 18:16, 22:20 and 26:24. The counts are captured when the request is accepted.
- R3: The strobe falls exactly S clock cycles after the chip select falls, where S is the setup count, or 16 when the count is 0.
- R4: With ready checking disabled for the selected chip select, the strobe stays low for exactly P cycles, where P is the pulse count, or 1 when the count is 0, whatever the ready input does.
- R5: The chip select rises exactly H cycles after the strobe rises, where H is the hold count, or 16 when the count is 0.
- R6: With ready checking enabled (rdy_en bit indexed by the chip select), ready_in is active high and passes through two flops. The strobe stays low past P cycles until a clock edge at which the synchronised ready is high. If ready_in rises during the m-th low cycle, the strobe width is max(P, m+2) cycles.
- R7: Only the requested chip-select bit (bit req_sel of cs_n) goes low. req_write=1 strobes wr_n and req_write=0 strobes rd_n. The other strobe and the other chip select stay high.
- R8: done is high for exactly one cycle, starting at the edge where the chip select rises. busy is high from request acceptance until that edge.
- R9: A request while busy is ignored. It neither disturbs the cycle in progress nor asserts the other chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write enable for the timing word |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Timing word read data |
| req_valid | input | 1 | Request a bus cycle (taken when not busy) |
| req_sel | input | 1 | Chip select index of the request |
| req_write | input | 1 | 1 = write strobe, 0 = read strobe |
| rdy_en | input | 2 | Per-chip-select ready checking enable |
| ready_in | input | 1 | Asynchronous ready, active high |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-cycle pulse when the hold phase ends |
| cs_n | output | 2 | Active-low chip selects |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
The assertions take for granted that req_sel is held stable only for the cycle of the request, and that the timing word is not required to change a cycle already running. The bench writes the timing word only while the block is idle. The ready-related properties assume ready_in eventually rises once ready checking is on. The stimulus keeps ready_in high except during wait-state trials, where it raises ready at a chosen strobe cycle. Ready is held low for several cycles before each such request, so the synchroniser has settled.

// File: rtl/cst_pkg.sv
package cst_pkg;
    localparam int NUM_CS     = 2;
    localparam int SEL_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
    localparam int REG_W      = 32;
    localparam int CNT_W      = 3;
    localparam int CS_STRIDE  = 16;
    localparam int SETUP_LSB  = 0;
    localparam int PULSE_LSB  = 4;
    localparam int HOLD_LSB   = 8;
    localparam int ZERO_EDGE  = 16;
    localparam int PH_W       = $clog2(ZERO_EDGE);
    localparam logic [REG_W-1:0] RESET_WORD = 32'h0777_0777;

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [PH_W-1:0]  ph_t;

    typedef struct packed {
        cnt_t setup;
        cnt_t pulse;
        cnt_t hold;
    } timing_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_WAIT,
        ST_HOLD
    } phase_e;

    function automatic timing_t unpack_timing(input logic [REG_W-1:0] w, input int idx);
        timing_t t;
        t.setup = w[idx*CS_STRIDE + SETUP_LSB +: CNT_W];
        t.pulse = w[idx*CS_STRIDE + PULSE_LSB +: CNT_W];
        t.hold  = w[idx*CS_STRIDE + HOLD_LSB  +: CNT_W];
        return t;
    endfunction

    // Counter load for setup/hold: cycles-1, zero meaning ZERO_EDGE cycles.
    function automatic ph_t edge_load(input cnt_t c);
        if (c == '0)
            return ph_t'(ZERO_EDGE - 1);
        return ph_t'(c) - ph_t'(1);
    endfunction

    // Counter load for the pulse: cycles-1, zero meaning one cycle.
    function automatic ph_t pulse_load(input cnt_t c);
        if (c == '0)
            return '0;
        return ph_t'(c) - ph_t'(1);
    endfunction
endpackage

// File: rtl/cst_timing_reg.sv
module cst_timing_reg
    import cst_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [REG_W-1:0]           wdata,
    output logic [REG_W-1:0]           rdata,
    output timing_t [NUM_CS-1:0]       tim
);
    logic [REG_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= RESET_WORD;
        else if (we)
            word_q <= wdata;
    end

    assign rdata = word_q;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_fields
        assign tim[i] = unpack_timing(word_q, i);
    end
endmodule

// File: rtl/cst_ready_sync.sv
module cst_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst)
            chain[0] <= 1'b0;
        else
            chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[i] <= 1'b0;
            else
                chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cst_sequencer.sv
module cst_sequencer
    import cst_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [SEL_W-1:0]      req_sel,
    input  logic                  req_write,
    input  logic [NUM_CS-1:0]     rdy_en,
    input  logic                  rdy_s,
    input  timing_t [NUM_CS-1:0]  tim,
    output logic                  busy,
    output logic                  done,
    output logic [NUM_CS-1:0]     cs_n,
    output logic                  rd_n,
    output logic                  wr_n
);
    phase_e          st, st_nx;
    ph_t             cnt, cnt_nx;
    timing_t         tq;
    logic [SEL_W-1:0] sel_q, sel_nx;
    logic            wr_q, wr_nx;
    logic            chk_q;
    logic            start;
    logic            done_nx;
    logic            strobe_nx;
    logic            cs_on_nx;

    assign start  = (st == ST_IDLE) && req_valid;
    assign sel_nx = (st == ST_IDLE) ? req_sel   : sel_q;
    assign wr_nx  = (st == ST_IDLE) ? req_write : wr_q;

    always_comb begin
        st_nx   = st;
        cnt_nx  = cnt;
        done_nx = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (req_valid) begin
                    st_nx  = ST_SETUP;
                    cnt_nx = edge_load(tim[req_sel].setup);
                end
            end
            ST_SETUP: begin
                if (cnt == '0) begin
                    st_nx  = ST_STROBE;
                    cnt_nx = pulse_load(tq.pulse);
                end else begin
                    cnt_nx = cnt - ph_t'(1);
                end
            end
            ST_STROBE: begin
                if (cnt == '0) begin
                    if (chk_q && !rdy_s) begin
                        st_nx = ST_WAIT;
                    end else begin
                        st_nx  = ST_HOLD;
                        cnt_nx = edge_load(tq.hold);
                    end
                end else begin
                    cnt_nx = cnt - ph_t'(1);
                end
            end
            ST_WAIT: begin
                if (rdy_s) begin
                    st_nx  = ST_HOLD;
                    cnt_nx = edge_load(tq.hold);
                end
            end
            ST_HOLD: begin
                if (cnt == '0) begin
                    st_nx   = ST_IDLE;
                    done_nx = 1'b1;
                end else begin
                    cnt_nx = cnt - ph_t'(1);
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    assign cs_on_nx  = (st_nx != ST_IDLE);
    assign strobe_nx = (st_nx == ST_STROBE) || (st_nx == ST_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            tq    <= '0;
            sel_q <= '0;
            wr_q  <= 1'b0;
            chk_q <= 1'b0;
            done  <= 1'b0;
            rd_n  <= 1'b1;
            wr_n  <= 1'b1;
        end else begin
            st   <= st_nx;
            cnt  <= cnt_nx;
            done <= done_nx;
            rd_n <= !(strobe_nx && !wr_nx);
            wr_n <= !(strobe_nx &&  wr_nx);
            if (start) begin
                tq    <= tim[req_sel];
                sel_q <= req_sel;
                wr_q  <= req_write;
                chk_q <= rdy_en[req_sel];
            end
        end
    end

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        always_ff @(posedge clk) begin
            if (rst)
                cs_n[i] <= 1'b1;
            else
                cs_n[i] <= !(cs_on_nx && (sel_nx == SEL_W'(i)));
        end
    end

    assign busy = (st != ST_IDLE);
endmodule

// File: rtl/cst_strobe_timer.sv
module cst_strobe_timer
    import cst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [REG_W-1:0]      cfg_wdata,
    output logic [REG_W-1:0]      cfg_rdata,
    input  logic                  req_valid,
    input  logic [SEL_W-1:0]      req_sel,
    input  logic                  req_write,
    input  logic [NUM_CS-1:0]     rdy_en,
    input  logic                  ready_in,
    output logic                  busy,
    output logic                  done,
    output logic [NUM_CS-1:0]     cs_n,
    output logic                  rd_n,
    output logic                  wr_n
);
    timing_t [NUM_CS-1:0] tim;
    logic                 rdy_s;

    cst_timing_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .tim   (tim)
    );

    cst_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ready_in),
        .q   (rdy_s)
    );

    cst_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_sel   (req_sel),
        .req_write (req_write),
        .rdy_en    (rdy_en),
        .rdy_s     (rdy_s),
        .tim       (tim),
        .busy      (busy),
        .done      (done),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n)
    );
endmodule

// File: rtl/cst_checker.sv
module cst_checker
    import cst_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [NUM_CS-1:0] cs_n,
    input logic              rd_n,
    input logic              wr_n
);
    localparam logic [NUM_CS-1:0] ALL_OFF = '1;

    assert_one_select_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_n & wr_n) |-> ($past(cs_n) != ALL_OFF));

    assert_hold_after_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_n & wr_n) |-> (cs_n != ALL_OFF));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_at_release_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (cs_n == ALL_OFF) && ($past(cs_n) != ALL_OFF));

    assert_keep_select_R9: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid && cs_n != ALL_OFF) |=> (cs_n == ALL_OFF) || (cs_n == $past(cs_n)));
endmodule

bind cst_strobe_timer cst_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n)
);

// File: tb/sim_cst_strobe_timer.sv
module sim_cst_strobe_timer;
    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        req_valid;
    logic [0:0]  req_sel;
    logic        req_write;
    logic [1:0]  rdy_en;
    logic        ready_in;
    logic        busy;
    logic        done;
    logic [1:0]  cs_n;
    logic        rd_n;
    logic        wr_n;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cst_strobe_timer u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_sel(req_sel),
        .req_write(req_write), .rdy_en(rdy_en), .ready_in(ready_in),
        .busy(busy), .done(done), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] field(input int cs, input int s, input int p, input int h);
        logic [31:0] w;
        w = '0;
        w[cs*16 +: 3]     = 3'(s);
        w[cs*16 + 4 +: 3] = 3'(p);
        w[cs*16 + 8 +: 3] = 3'(h);
        return w;
    endfunction

    task automatic write_word(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rdata == w, "R1 readback", int'(cfg_rdata), int'(w));
    endtask

    // m > 0: raise ready_in at the m-th strobe-low sample; poke: request during busy
    task automatic run_txn(input int cs, input bit wr, input int s, input int p, input int h,
                           input bit chk, input int m, input bit poke);
        int se, pe, he, we_exp;
        int n_setup, n_low, n_hold, n_bad;
        bit seen_low, got_done, poked;
        logic strb, other;
        se = (s == 0) ? 16 : s;
        pe = (p == 0) ? 1 : p;
        he = (h == 0) ? 16 : h;
        we_exp = (chk && m > 0) ? ((m + 2 > pe) ? m + 2 : pe) : pe;
        n_setup = 0; n_low = 0; n_hold = 0; n_bad = 0;
        seen_low = 0; got_done = 0; poked = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_sel   = 1'(cs);
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R8 busy after accept", int'(busy), 1);
        for (int k = 0; k < 120; k++) begin
            if (k > 0) @(negedge clk);
            if (poked) begin
                req_valid = 1'b0;
            end
            strb  = wr ? wr_n : rd_n;
            other = wr ? rd_n : wr_n;
            if (cs_n[1-cs] != 1'b1 || other != 1'b1) n_bad++;
            if (done) begin
                got_done = 1;
                check(cs_n == 2'b11, "R8 release with done", int'(cs_n), 3);
                break;
            end
            if (cs_n[cs] == 1'b0) begin
                if (strb == 1'b0) begin
                    n_low++;
                    seen_low = 1;
                    if (chk && m > 0 && n_low == m) ready_in = 1'b1;
                end else if (!seen_low) begin
                    n_setup++;
                    if (poke && n_setup == 1) begin
                        req_valid = 1'b1;
                        req_sel   = 1'(1 - cs);
                        req_write = !wr;
                        poked = 1;
                    end
                end else begin
                    n_hold++;
                end
            end else begin
                n_bad++;
            end
        end
        req_valid = 1'b0;
        check(got_done, "R8 done seen", int'(got_done), 1);
        check(n_setup == se, "R3 setup cycles", n_setup, se);
        check(n_low == we_exp, chk ? "R6 strobe width" : "R4 strobe width", n_low, we_exp);
        check(n_hold == he, "R5 hold cycles", n_hold, he);
        check(n_bad == 0, poke ? "R9 ignored request" : "R7 selection", n_bad, 0);
        @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R8 done one cycle", int'({done, busy}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0; req_valid = 1'b0;
        req_sel = '0; req_write = 1'b0; rdy_en = 2'b00; ready_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cfg_rdata == 32'h0777_0777, "R1 reset word", int'(cfg_rdata), 32'h0777_0777);
        check(cs_n == 2'b11 && rd_n && wr_n, "R7 idle outputs", int'({cs_n, rd_n, wr_n}), 15);
        check(!busy && !done, "R8 idle status", int'({busy, done}), 0);
        run_txn(0, 0, 7, 7, 7, 0, 0, 0);
        run_txn(1, 1, 7, 7, 7, 0, 0, 0);

        // R2 sweep: selected fields differ from the other chip select's fields
        for (int cs = 0; cs < 2; cs++) begin
            for (int s = 0; s < 8; s++) begin
                for (int p = 0; p < 8; p++) begin
                    int h;
                    h = (s + 3 * p) % 8;
                    write_word(field(cs, s, p, h) | field(1 - cs, 7 - s, 7 - p, 7 - h)
                               | (32'h5A08_B808 & 32'hF888_F888));
                    run_txn(cs, 1'((s ^ p) & 1), s, p, h, 0, 0, 0);
                end
            end
        end

        // R9: request for the other chip select while busy
        write_word(field(0, 3, 2, 4) | field(1, 1, 1, 1));
        run_txn(0, 0, 3, 2, 4, 0, 0, 1);
        write_word(field(1, 2, 3, 2) | field(0, 1, 1, 1));
        run_txn(1, 1, 2, 3, 2, 0, 0, 1);

        // R4: ready low but checking disabled
        rdy_en = 2'b10;
        ready_in = 1'b0;
        repeat (4) @(negedge clk);
        write_word(field(0, 2, 3, 2) | field(1, 2, 3, 2));
        run_txn(0, 1, 2, 3, 2, 0, 0, 0);

        // R6: wait states with ready raised at different strobe cycles
        for (int cs = 0; cs < 2; cs++) begin
            rdy_en = cs == 0 ? 2'b01 : 2'b10;
            for (int pi = 0; pi < 2; pi++) begin
                for (int mi = 0; mi < 3; mi++) begin
                    int p, m;
                    p = pi == 0 ? 2 : 5;
                    m = mi == 0 ? 1 : (mi == 1 ? 3 : 6);
                    write_word(field(cs, 1, p, 2) | field(1 - cs, 5, 5, 5));
                    ready_in = 1'b0;
                    repeat (4) @(negedge clk);
                    run_txn(cs, 1'(mi & 1), 1, p, 2, 1, m, 0);
                end
            end
            ready_in = 1'b1;
            repeat (4) @(negedge clk);
            write_word(field(cs, 2, 4, 3) | field(1 - cs, 6, 6, 6));
            run_txn(cs, 0, 2, 4, 3, 1, 0, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule